// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the control state machine of an on-chip clock generator that is built around a frequency-locked loop and a digitally controlled oscillator. A two-bit clock-select field picks the operating mode. The block then follows that choice, subject to a stop request, an oscillator-stable flag, a loop-lock flag and an external-reference-loss flag. It reports the active mode and drives a write enable for the oscillator filter register. It also holds the filter value, which stands in for the oscillator frequency setting, and drives a selector that doubles the output divider. It does not model the oscillator, the pulse counter or the loop arithmetic.

The states are as follows. SELF is self-clocked: the loop is open and the output is the oscillator clock divided by R. INTL is the loop engaged on the internal reference. BYP is the external clock bypassed straight through. EXTL is the loop engaged on the external reference. OFF is entered by a stop request. WAKE is self-clocked and waits for the oscillator to settle after OFF.

The transitions are as follows. A select change moves SELF, INTL, BYP and EXTL between one another. A stop request moves any state to OFF. When the stop request is released, OFF goes to WAKE for selects 01 and 11, to SELF for 00 and to BYP for 10. WAKE closes the loop into INTL or EXTL once the oscillator is stable. Loss of the external reference moves BYP or EXTL to SELF. The filter value only changes through writes made in the self-clocked states. Because of this it survives every mode change, including a pass through OFF.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset the block has mode_o = 00, off_o = 0, flt_o = FLT_RST, dbl_o = 0, loss_o = 0, irq_o = 0 and flt_wen_o = 1.
- R2: Outside OFF and WAKE, and with no stop and no loss, the next cycle enters the state named by sel_i. The codes are 00 SELF, 01 INTL, 10 BYP and 11 EXTL, and mode_o shows the same code.
- R3: flt_wen_o is 1 exactly in SELF and WAKE. A filter write lands one cycle later only in those states, and in every other state it leaves flt_o unchanged.
- R4: A move from INTL or EXTL back to SELF keeps the earlier filter value.
- R5: A stop request makes off_o = 1 on the next cycle, with mode_o = 00. On release, select 00 gives SELF and select 10 gives BYP, and flt_o still holds the value from before OFF.
- R6: A release from OFF with select 01 or 11 gives mode_o = 00 (WAKE) until dco_stable_i is high. The cycle after that, the block is in INTL for 01 or EXTL for 11.
- R7: ext_loss_i in BYP or EXTL forces SELF on the next cycle and sets loss_o, and irq_o = loss_o AND irq_en_i. In SELF and INTL the loss has no effect. While the loss persists, SELF does not enter BYP or EXTL.
- R8: An exit from EXTL to SELF (by select or by loss) with fll_lock_i low sets dbl_o. With the lock high it leaves dbl_o at 0.
- R9: dbl_o clears on the cycle after fll_lock_i is high, or after any state change.
- R10: loss_o clears on entry to BYP or EXTL.
- R11: A stop request takes priority over the select and over a reference loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Clock-select field |
| stop_i | input | 1 | Stop request (enter OFF) |
| dco_stable_i | input | 1 | Oscillator settled |
| fll_lock_i | input | 1 | Loop locked |
| ext_loss_i | input | 1 | External reference lost |
| irq_en_i | input | 1 | Loss interrupt enable |
| flt_wr_i | input | 1 | Filter write strobe |
| flt_wdata_i | input | FLT_W | Filter write value |
| mode_o | output | 2 | Active mode code |
| off_o | output | 1 | Block is in OFF |
| flt_wen_o | output | 1 | Filter writes accepted |
| flt_o | output | FLT_W | Oscillator filter value |
| dbl_o | output | 1 | Output divider doubled |
| loss_o | output | 1 | Reference-loss status |
| irq_o | output | 1 | Reference-loss interrupt |

## Verification
The assertions assume that sel_i, stop_i, ext_loss_i and dco_stable_i are synchronous to clk and settle before each rising edge. They also assume that fll_lock_i is a level that the clock generator itself drives. The bench drives every input only just after a rising edge and holds it for the whole cycle. It clears ext_loss_i before asking for an externally referenced mode again, so that the assertion on forced fallback never sees a loss that the select keeps fighting.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    typedef enum logic [2:0] {
        ST_SELF = 3'd0,
        ST_INTL = 3'd1,
        ST_BYP  = 3'd2,
        ST_EXTL = 3'd3,
        ST_OFF  = 3'd4,
        ST_WAKE = 3'd5
    } cg_state_e;

    localparam logic [1:0] SEL_SELF = 2'b00;
    localparam logic [1:0] SEL_INTL = 2'b01;
    localparam logic [1:0] SEL_BYP  = 2'b10;
    localparam logic [1:0] SEL_EXTL = 2'b11;
endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       stop_i,
    input  logic       dco_stable_i,
    input  logic       ext_loss_i,
    output cg_state_e  state_q,
    output logic       ev_ext_exit,
    output logic       ev_loss,
    output logic       ev_chg,
    output logic       ev_ext_entry
);
    cg_state_e state_d;

    function automatic cg_state_e sel_to_state(input logic [1:0] s);
        unique case (s)
            SEL_INTL: sel_to_state = ST_INTL;
            SEL_BYP:  sel_to_state = ST_BYP;
            SEL_EXTL: sel_to_state = ST_EXTL;
            default:  sel_to_state = ST_SELF;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SELF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ev_loss = 1'b0;
        if (stop_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_SELF: begin
                    if (!(ext_loss_i && sel_i[1])) state_d = sel_to_state(sel_i);
                end
                ST_INTL: state_d = sel_to_state(sel_i);
                ST_BYP, ST_EXTL: begin
                    if (ext_loss_i) begin
                        state_d = ST_SELF;
                        ev_loss = 1'b1;
                    end else begin
                        state_d = sel_to_state(sel_i);
                    end
                end
                ST_OFF: begin
                    if (sel_i[0]) state_d = ST_WAKE;
                    else          state_d = sel_to_state(sel_i);
                end
                ST_WAKE: begin
                    if (dco_stable_i) state_d = sel_to_state(sel_i);
                end
                default: state_d = ST_SELF;
            endcase
        end
    end

    always_comb begin
        ev_chg       = (state_d != state_q);
        ev_ext_exit  = (state_q == ST_EXTL) && (state_d == ST_SELF);
        ev_ext_entry = ev_chg && ((state_d == ST_EXTL) || (state_d == ST_BYP));
    end

    AST_WAKE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && dco_stable_i && !stop_i && sel_i == SEL_INTL) |=> state_q == ST_INTL); // R6
    AST_OFF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !stop_i && sel_i[0]) |=> state_q == ST_WAKE); // R6
    AST_LOSS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BYP || state_q == ST_EXTL) && ext_loss_i && !stop_i) |=> state_q == ST_SELF); // R7
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> state_q == ST_OFF); // R11
endmodule

// File: rtl/clkgen_flt_reg.sv
module clkgen_flt_reg #(
    parameter int FLT_W = 10,
    parameter logic [FLT_W-1:0] FLT_RST = 10'd64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen_i,
    input  logic             wr_i,
    input  logic [FLT_W-1:0] wdata_i,
    output logic [FLT_W-1:0] flt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            flt_q <= FLT_RST;
        else if (wen_i && wr_i) flt_q <= wdata_i;
    end

    AST_FLT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_i |=> $stable(flt_q)); // R3
endmodule

// File: rtl/clkgen_out_ctl.sv
module clkgen_out_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_ext_exit,
    input  logic ev_loss,
    input  logic ev_chg,
    input  logic ev_ext_entry,
    input  logic fll_lock_i,
    input  logic in_self_i,
    output logic dbl_q,
    output logic loss_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbl_q <= 1'b0;
        end else if (ev_ext_exit && !fll_lock_i) begin
            dbl_q <= 1'b1;
        end else if (fll_lock_i || ev_chg) begin
            dbl_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            loss_q <= 1'b0;
        else if (ev_loss)      loss_q <= 1'b1;
        else if (ev_ext_entry) loss_q <= 1'b0;
    end

    AST_DBL_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_q |-> in_self_i); // R8
    AST_DBL_LOCK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (fll_lock_i && !ev_ext_exit) |=> !dbl_q); // R9
    AST_LOSS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_loss |=> loss_q); // R7
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int FLT_W = 10,
    parameter logic [FLT_W-1:0] FLT_RST = 10'd64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel_i,
    input  logic             stop_i,
    input  logic             dco_stable_i,
    input  logic             fll_lock_i,
    input  logic             ext_loss_i,
    input  logic             irq_en_i,
    input  logic             flt_wr_i,
    input  logic [FLT_W-1:0] flt_wdata_i,
    output logic [1:0]       mode_o,
    output logic             off_o,
    output logic             flt_wen_o,
    output logic [FLT_W-1:0] flt_o,
    output logic             dbl_o,
    output logic             loss_o,
    output logic             irq_o
);
    cg_state_e state_q;
    logic ev_ext_exit, ev_loss, ev_chg, ev_ext_entry;
    logic in_self;

    clkgen_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stop_i(stop_i),
        .dco_stable_i(dco_stable_i), .ext_loss_i(ext_loss_i),
        .state_q(state_q), .ev_ext_exit(ev_ext_exit), .ev_loss(ev_loss),
        .ev_chg(ev_chg), .ev_ext_entry(ev_ext_entry)
    );

    always_comb begin
        in_self = 1'b0;
        off_o   = 1'b0;
        mode_o  = SEL_SELF;
        unique case (state_q)
            ST_SELF, ST_WAKE: in_self = 1'b1;
            ST_INTL:          mode_o  = SEL_INTL;
            ST_BYP:           mode_o  = SEL_BYP;
            ST_EXTL:          mode_o  = SEL_EXTL;
            ST_OFF:           off_o   = 1'b1;
            default:          in_self = 1'b1;
        endcase
        flt_wen_o = in_self;
    end

    clkgen_flt_reg #(.FLT_W(FLT_W), .FLT_RST(FLT_RST)) u_flt (
        .clk(clk), .rst_n(rst_n), .wen_i(in_self), .wr_i(flt_wr_i),
        .wdata_i(flt_wdata_i), .flt_q(flt_o)
    );

    clkgen_out_ctl u_out (
        .clk(clk), .rst_n(rst_n), .ev_ext_exit(ev_ext_exit), .ev_loss(ev_loss),
        .ev_chg(ev_chg), .ev_ext_entry(ev_ext_entry), .fll_lock_i(fll_lock_i),
        .in_self_i(in_self), .dbl_q(dbl_o), .loss_q(loss_o)
    );

    assign irq_o = loss_o & irq_en_i;

    AST_OFF_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |-> (mode_o == SEL_SELF && !flt_wen_o)); // R5
endmodule

// File: tb/clkgen_mode_ctrl_test.sv
module clkgen_mode_ctrl_test;
    localparam int FLT_W = 10;
    localparam logic [FLT_W-1:0] FLT_RST = 10'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel_i = 2'b00;
    logic stop_i = 0, dco_stable_i = 0, fll_lock_i = 0, ext_loss_i = 0;
    logic irq_en_i = 1, flt_wr_i = 0;
    logic [FLT_W-1:0] flt_wdata_i = '0;
    logic [1:0] mode_o;
    logic off_o, flt_wen_o, dbl_o, loss_o, irq_o;
    logic [FLT_W-1:0] flt_o;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    clkgen_mode_ctrl #(.FLT_W(FLT_W), .FLT_RST(FLT_RST)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stop_i(stop_i),
        .dco_stable_i(dco_stable_i), .fll_lock_i(fll_lock_i), .ext_loss_i(ext_loss_i),
        .irq_en_i(irq_en_i), .flt_wr_i(flt_wr_i), .flt_wdata_i(flt_wdata_i),
        .mode_o(mode_o), .off_o(off_o), .flt_wen_o(flt_wen_o), .flt_o(flt_o),
        .dbl_o(dbl_o), .loss_o(loss_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic go_self();
        stop_i = 0; ext_loss_i = 0; fll_lock_i = 0; sel_i = 2'b00;
        step();
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 off", off_o, 0);
        chk("R1 flt", flt_o, FLT_RST);
        chk("R1 dbl", dbl_o, 0);
        chk("R1 loss", loss_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 wen", flt_wen_o, 1);
    endtask

    task automatic t_filter();
        flt_wr_i = 1; flt_wdata_i = 10'd100; step(); flt_wr_i = 0;
        chk("R3 write in self", flt_o, 100);
        sel_i = 2'b01; step();
        chk("R2 intl", mode_o, 1);
        chk("R3 wen intl", flt_wen_o, 0);
        flt_wr_i = 1; flt_wdata_i = 10'd55; step(); flt_wr_i = 0;
        chk("R3 write ignored", flt_o, 100);
        sel_i = 2'b10; step();
        chk("R2 byp", mode_o, 2);
        sel_i = 2'b00; step();
        chk("R4 back to self", mode_o, 0);
        chk("R4 flt kept", flt_o, 100);
    endtask

    task automatic t_ext_dbl();
        sel_i = 2'b11; fll_lock_i = 0; step();
        chk("R2 extl", mode_o, 3);
        sel_i = 2'b00; step();
        chk("R8 unlocked exit dbl", dbl_o, 1);
        chk("R4 flt kept ext", flt_o, 100);
        step();
        chk("R9 dbl holds", dbl_o, 1);
        fll_lock_i = 1; step();
        chk("R9 lock clears", dbl_o, 0);
        sel_i = 2'b11; step();
        sel_i = 2'b00; step();
        chk("R8 locked exit", dbl_o, 0);
        fll_lock_i = 0; sel_i = 2'b11; step();
        sel_i = 2'b00; step();
        chk("R8 set again", dbl_o, 1);
        sel_i = 2'b01; step();
        chk("R9 change clears", dbl_o, 0);
        go_self();
    endtask

    task automatic t_loss();
        sel_i = 2'b10; step();
        ext_loss_i = 1; step();
        chk("R7 byp fallback", mode_o, 0);
        chk("R7 flag", loss_o, 1);
        chk("R7 irq", irq_o, 1);
        irq_en_i = 0; #1;
        chk("R7 irq masked", irq_o, 0);
        irq_en_i = 1;
        step();
        chk("R7 stays self", mode_o, 0);
        ext_loss_i = 0; sel_i = 2'b11; step();
        chk("R10 extl entry", mode_o, 3);
        chk("R10 flag cleared", loss_o, 0);
        ext_loss_i = 1; step();
        chk("R7 extl fallback", mode_o, 0);
        chk("R8 loss unlocked dbl", dbl_o, 1);
        ext_loss_i = 0; sel_i = 2'b01; step();
        chk("R2 intl after loss", mode_o, 1);
        ext_loss_i = 1; step();
        chk("R7 intl ignores loss", mode_o, 1);
        go_self();
    endtask

    task automatic t_off();
        flt_wr_i = 1; flt_wdata_i = 10'd77; step(); flt_wr_i = 0;
        stop_i = 1; step();
        chk("R5 off", off_o, 1);
        chk("R5 mode in off", mode_o, 0);
        flt_wr_i = 1; flt_wdata_i = 10'd9; step(); flt_wr_i = 0;
        chk("R3 write in off", flt_o, 77);
        stop_i = 0; sel_i = 2'b00; step();
        chk("R5 exit self", off_o, 0);
        chk("R5 flt restored", flt_o, 77);
        stop_i = 1; step();
        stop_i = 0; sel_i = 2'b10; step();
        chk("R5 exit byp", mode_o, 2);
        go_self();
    endtask

    task automatic t_wake(input logic [1:0] s, input int want);
        stop_i = 1; dco_stable_i = 0; step();
        stop_i = 0; sel_i = s; step();
        chk("R6 wake self-clocked", mode_o, 0);
        chk("R6 wake not off", off_o, 0);
        step();
        chk("R6 waits for stable", mode_o, 0);
        dco_stable_i = 1; step();
        chk("R6 loop closed", mode_o, want);
        dco_stable_i = 0;
        go_self();
    endtask

    task automatic t_stop_prio();
        sel_i = 2'b11; step();
        stop_i = 1; ext_loss_i = 1; step();
        chk("R11 stop wins", off_o, 1);
        chk("R11 no loss flag", loss_o, 0);
        go_self();
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_filter();
        t_ext_dbl();
        t_loss();
        t_off();
        t_wake(2'b01, 1);
        t_wake(2'b11, 3);
        t_stop_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule